// File: doc/BRIEF.md
# Time-Slotted Fiber Word Scheduler

This block merges the contents of five memory sources onto the 20-bit parallel input of a fiber serializer. During data transfer it runs a repeating nine-step frame. Sources 1 to 4 each present a 40-bit word, and the block sends each word as two 20-bit halves in that source's own pair of steps. Source 5 owns one step and supplies only 20 meaningful bits. At the start of every frame the block issues a sync pulse so the sources stay aligned with the step count. It also issues a one-hot strobe that tells each source when its word has been consumed.

A transfer starts with a pulse on the start input. The block then sends these items in order:
- a start-of-header control word;
- a fixed number of header words, taken from source 1 only;
- a start-of-data control word;
- as many data frames as the master's data-valid signal allows;
- an end-of-data control word.

Every control word is marked by a command-valid flag. The serializer side runs at 60 MHz. The block is fully synchronous to that clock, and its outputs are combinational from its state and the current source inputs.

Top module: `fiber_slot_sched`

## Requirements
- R1: After reset the block is idle: `busy_o`, `cav_o`, `dat_o` and `sync_o` are 0, `src_adv_o` is 0 and `ser_data_o` is 0.
- R2: A start pulse while idle makes the next cycle carry the start-of-header control word (default 20'h5A001) with `cav_o` high for exactly one cycle. `cav_o` and `dat_o` are never high together.
- R3: The header follows as HDR_WORDS (default 4) 40-bit words from source 1 (bits 39:0 of `src_words_i`). Each word is sent low 20 bits first, then high 20 bits, with `dat_o` high. `src_adv_o` bit 0 pulses on the second half.
- R4: The cycle right after the last header half carries the start-of-data control word (default 20'h5A002) with `cav_o` high.
- R5: In a data frame, step s (0 to 8) carries source k = s/2 + 1. An even step carries bits 19:0 and an odd step carries bits 39:20 of that source's word, where source k occupies `src_words_i[40k-1 : 40k-40]`. Step 8 carries only bits 19:0 of source 5, and bits 39:20 of source 5 are never sent.
- R6: `sync_o` is high in step 0 of every data frame and in no other cycle.
- R7: In data frames `src_adv_o` is one-hot on the last step of each source's slot: bit k-1 on step 2k-1 for sources 1 to 4, and bit 4 on step 8. It is zero on all other steps.
- R8: A frame begins only when `dval_i` is high at a frame boundary. Once begun, the frame runs all nine steps whatever `dval_i` does. A boundary with `dval_i` low sends nothing (`dat_o` low).
- R9: The cycle after a boundary with `dval_i` low carries the end-of-data control word (default 20'h5A003) with `cav_o` high, and the block then returns to idle. `start_i` has no effect while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serializer-side clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a transfer (honoured only when idle) |
| dval_i | input | 1 | Data-valid from the master source, sampled at frame boundaries |
| src_words_i | input | 200 | Five 40-bit source words, source 1 in the low bits |
| ser_data_o | output | 20 | Word presented to the serializer |
| dat_o | output | 1 | `ser_data_o` holds a header or data half |
| cav_o | output | 1 | `ser_data_o` holds a control word |
| sync_o | output | 1 | First step of a data frame |
| src_adv_o | output | 5 | Per-source strobe: this source's word has been consumed |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench checks half ordering and source-to-step mapping with word values that differ in every half and every frame. A design that swapped halves, or that was off by one in the source index, would show the wrong pattern at a named step. Source 5 is given all-ones in its upper bits, so a design that sent a sixth half or picked the wrong half at step 8 is caught. Data-valid is dropped in the middle of the last frame; a design that aborted the frame would end early and send the end-of-data word out of place. A transfer with no data frames at all must go straight from start-of-data through an empty boundary to end-of-data. The start input is held high through the whole transfer, so a design that restarted while busy would put a start-of-header word in the middle of the stream.

// File: rtl/fiber_slot_sched.sv
module fiber_slot_sched #(
  parameter int W         = 20,
  parameter int NSRC      = 5,
  parameter int HDR_WORDS = 4,
  parameter logic [19:0] SOH_CW = 20'h5A001,
  parameter logic [19:0] SOD_CW = 20'h5A002,
  parameter logic [19:0] EOD_CW = 20'h5A003
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  dval_i,
  input  logic [NSRC*2*W-1:0]   src_words_i,
  output logic [W-1:0]          ser_data_o,
  output logic                  dat_o,
  output logic                  cav_o,
  output logic                  sync_o,
  output logic [NSRC-1:0]       src_adv_o,
  output logic                  busy_o
);

  localparam int STEPS = 2*NSRC - 1;
  localparam int SW    = $clog2(STEPS);
  localparam int HW    = (HDR_WORDS > 1) ? $clog2(HDR_WORDS) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SOH, S_HDR, S_SOD, S_DATA, S_EOD} st_t;

  st_t            st;
  logic [SW-1:0]  step;
  logic [HW-1:0]  hcnt;
  logic           go, hdr_act;
  int unsigned    sidx;

  assign hdr_act = (st == S_HDR);
  assign go      = (st == S_DATA) && ((step != '0) || dval_i);
  assign dat_o   = go || hdr_act;
  assign cav_o   = (st == S_SOH) || (st == S_SOD) || (st == S_EOD);
  assign sync_o  = go && (step == '0);
  assign busy_o  = (st != S_IDLE);
  assign sidx    = hdr_act ? 0 : 32'(step >> 1);

  always_comb begin
    ser_data_o = '0;
    case (st)
      S_SOH:   ser_data_o = SOH_CW[W-1:0];
      S_SOD:   ser_data_o = SOD_CW[W-1:0];
      S_EOD:   ser_data_o = EOD_CW[W-1:0];
      default: if (dat_o) ser_data_o = src_words_i[sidx*2*W + 32'(step[0])*W +: W];
    endcase
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_adv
    if (i < NSRC-1) begin : g_pair
      if (i == 0) begin : g_master
        assign src_adv_o[i] = (go && step == SW'(2*i+1)) || (hdr_act && step[0]);
      end else begin : g_other
        assign src_adv_o[i] = go && step == SW'(2*i+1);
      end
    end else begin : g_single
      assign src_adv_o[i] = go && step == SW'(STEPS-1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      step <= '0;
      hcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start_i) st <= S_SOH;
        S_SOH: begin
          st   <= S_HDR;
          step <= '0;
          hcnt <= '0;
        end
        S_HDR: begin
          if (step[0]) begin
            step <= '0;
            if (hcnt == HW'(HDR_WORDS-1)) st <= S_SOD;
            else hcnt <= hcnt + 1'b1;
          end else begin
            step <= SW'(1);
          end
        end
        S_SOD: begin
          st   <= S_DATA;
          step <= '0;
        end
        S_DATA: begin
          if (go) step <= (step == SW'(STEPS-1)) ? '0 : step + 1'b1;
          else    st   <= S_EOD;
        end
        S_EOD:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module fiber_slot_sched_chk #(parameter int NSRC = 5) (
  input logic            clk,
  input logic            rst_n,
  input logic            start_i,
  input logic            dval_i,
  input logic            dat_o,
  input logic            cav_o,
  input logic            sync_o,
  input logic [NSRC-1:0] src_adv_o,
  input logic            busy_o
);
  // R2
  cav_dat_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(cav_o && dat_o));
  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && start_i) |=> cav_o);
  // R2
  cav_single_chk: assert property (@(posedge clk) disable iff (!rst_n) cav_o |=> !cav_o);
  // R7
  adv_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(src_adv_o));
  // R6
  sync_needs_dval_chk: assert property (@(posedge clk) disable iff (!rst_n) sync_o |-> (dat_o && dval_i));
  // R8
  frame_continues_chk: assert property (@(posedge clk) disable iff (!rst_n) sync_o |=> (dat_o && !sync_o));
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy_o |-> (!dat_o && !cav_o && !sync_o));
endmodule

bind fiber_slot_sched fiber_slot_sched_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .dval_i(dval_i), .dat_o(dat_o),
  .cav_o(cav_o), .sync_o(sync_o), .src_adv_o(src_adv_o), .busy_o(busy_o)
);

// File: tb/fiber_slot_sched_bench.sv
module fiber_slot_sched_bench;
  localparam int HDR = 4;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         start_i = 0;
  logic         dval_i = 0;
  logic [199:0] src_words_i = '0;
  logic [19:0]  ser_data_o;
  logic         dat_o, cav_o, sync_o, busy_o;
  logic [4:0]   src_adv_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  fiber_slot_sched u_fiber_slot_sched (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dval_i(dval_i),
    .src_words_i(src_words_i), .ser_data_o(ser_data_o), .dat_o(dat_o),
    .cav_o(cav_o), .sync_o(sync_o), .src_adv_o(src_adv_o), .busy_o(busy_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] lo_of(input int k, input int f);
    return 20'((k+1)*4096 + f*16 + 1);
  endfunction

  function automatic logic [19:0] hi_of(input int k, input int f);
    return 20'h80000 | 20'((k+1)*256 + f);
  endfunction

  function automatic logic [199:0] pack(input int f);
    logic [199:0] v;
    for (int k = 0; k < 5; k++)
      v[k*40 +: 40] = {(k == 4) ? 20'hFFFFF : hi_of(k, f), lo_of(k, f)};
    return v;
  endfunction

  task automatic t_reset;
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 busy", int'(busy_o), 0);
    check("R1 cav", int'(cav_o), 0);
    check("R1 dat", int'(dat_o), 0);
    check("R1 sync", int'(sync_o), 0);
    check("R1 adv", int'(src_adv_o), 0);
    check("R1 data", int'(ser_data_o), 0);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_transfer(input int nfr);
    @(negedge clk);
    start_i = 1;
    dval_i = 0;
    #1 check("R1 idle before start", int'(busy_o), 0);
    @(negedge clk); #1;
    check("R2 cav", int'(cav_o), 1);
    check("R2 soh word", int'(ser_data_o), 'h5A001);
    for (int h = 0; h < HDR; h++) begin
      for (int half = 0; half < 2; half++) begin
        @(negedge clk);
        if (half == 0) src_words_i = pack(200 + h);
        #1;
        check("R3 dat", int'(dat_o), 1);
        check("R3 cav", int'(cav_o), 0);
        check("R3 header half", int'(ser_data_o),
              int'(half ? hi_of(0, 200 + h) : lo_of(0, 200 + h)));
        check("R3 adv", int'(src_adv_o), half);
      end
    end
    @(negedge clk); #1;
    check("R4 cav", int'(cav_o), 1);
    check("R4 sod word", int'(ser_data_o), 'h5A002);
    for (int f = 0; f < nfr; f++) begin
      for (int s = 0; s < 9; s++) begin
        @(negedge clk);
        if (s == 0) begin
          dval_i = 1;
          src_words_i = pack(f);
        end
        if (f == nfr-1 && s == 3) dval_i = 0;
        #1;
        check("R8 dat in frame", int'(dat_o), 1);
        check("R5 slot word", int'(ser_data_o),
              int'((s % 2) ? hi_of(s/2, f) : lo_of(s/2, f)));
        check("R6 sync", int'(sync_o), (s == 0) ? 1 : 0);
        check("R7 adv", int'(src_adv_o),
              (s == 8) ? 16 : ((s % 2) ? (1 << (s/2)) : 0));
      end
    end
    @(negedge clk);
    dval_i = 0;
    #1;
    check("R8 empty boundary dat", int'(dat_o), 0);
    check("R6 no sync at empty boundary", int'(sync_o), 0);
    @(negedge clk); #1;
    check("R9 cav", int'(cav_o), 1);
    check("R9 eod word", int'(ser_data_o), 'h5A003);
    @(negedge clk); #1;
    check("R9 idle after eod", int'(busy_o), 0);
    check("R9 no restart cav", int'(cav_o), 0);
    start_i = 0;
    @(negedge clk); #1;
    check("R9 stays idle", int'(busy_o), 0);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_transfer(3);
    t_transfer(0);
    t_transfer(1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule